// File: doc/BRIEF.md
# Horizontal 3-tap smoothing stage with rotating line buffers

This block is one streaming stage of an image filter. Pixels of an IMG_W by IMG_H image arrive in raster order, one per clock in which `pix_valid` is high. The stage runs a symmetric three-tap horizontal smoothing kernel over each row. It writes one result per accepted pixel into one of three line buffers. The buffer is picked by the row index modulo 3, so a later vertical stage can read the three most recent filtered rows side by side.

The in-row window is a three-slot register file. Pixel number c of a row goes into slot c mod 3. The newest pixel is fed straight to the kernel, so a row needs no extra beats. Each tap weight comes from a three-entry coefficient table, indexed by the absolute value of the tap offset (entry 0 for the centre, entry 1 for both neighbours). The weighted sum is shifted right by SHIFT and saturated to the pixel width. Border positions of the image are not filtered: they get a written zero. A consumer reads a buffer through a synchronous port with one cycle of latency.

Top module: `hsmooth_rot3`

## Requirements
- R1: Reset clears the column and row counters, both modulo-3 rotation pointers and `rd_data` (to 0). After reset, the next accepted pixel is row 0, column 0 of a new frame, even if reset came in the middle of a row.
- R2: For an interior position (row r in 1..IMG_H-2, column c in 1..IMG_W-2), the buffer holds min(2^PIX_W-1, (W1*p[c-1] + W0*p[c] + W1*p[c+1]) >> SHIFT). Here W0 is table entry 0 and W1 is table entry 1. The defaults are W0=8, W1=4 and SHIFT=4.
- R3: The tap weight depends only on the absolute offset. A row and its left-right mirror therefore give mirrored results.
- R4: Columns 0 and IMG_W-1 of every row receive the value 0.
- R5: Every column of rows 0 and IMG_H-1 receives the value 0.
- R6: Row r is written to buffer r mod 3 (buffer number on `rd_bank`, 0..2). It overwrites the row written three rows earlier.
- R7: A weighted, shifted sum above 2^PIX_W-1 is stored as 2^PIX_W-1.
- R8: A pixel accepted on one clock edge has its result written on the next edge. `rd_data` shows the addressed entry after the edge at which `rd_en` is high, and holds its value until then.
- R9: A cycle with `pix_valid` low changes neither the counters nor the window. Gaps in the stream leave the results unchanged.
- R10: After the last pixel of a frame, the next pixel starts row 0, column 0 with the buffer pointer at 0. No reset is needed between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid | input | 1 | Pixel beat qualifier |
| pix_data | input | PIX_W | Pixel value in raster order |
| rd_en | input | 1 | Read request for the line buffers |
| rd_bank | input | 2 | Line buffer to read (0..2) |
| rd_col | input | $clog2(IMG_W) | Column to read |
| rd_data | output | PIX_W | Registered read data |

## Verification
A pixel sampled at one rising edge has its result in the buffer after the following edge. A read request sampled at an edge presents its data after that edge. The bench therefore ends each row by dropping `pix_valid` at one falling edge and issues reads from the next falling edge on. It compares `rd_data` one falling edge after each request. A dedicated latency case changes the read column and samples just before the next rising edge, to show the old value is still held, then samples again after that edge.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  typedef logic [1:0] rot3_t;

  function automatic rot3_t rot3_next(input rot3_t p);
    return (p == 2'd2) ? 2'd0 : p + 2'd1;
  endfunction

  function automatic rot3_t rot3_prev(input rot3_t p);
    return (p == 2'd0) ? 2'd2 : p - 2'd1;
  endfunction

endpackage

// File: rtl/hsr_raster.sv
module hsr_raster
  import hsr_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 6,
  parameter int CW   = $clog2(COLS),
  parameter int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output rot3_t         cptr,
  output rot3_t         rptr
);

  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [CW-1:0] col_d;
  logic [RW-1:0] row_d;
  rot3_t         cptr_d;
  rot3_t         rptr_d;

  always_comb begin
    col_d  = col;
    row_d  = row;
    cptr_d = cptr;
    rptr_d = rptr;
    if (adv) begin
      if (col == LAST_COL) begin
        col_d  = '0;
        cptr_d = 2'd0;
        if (row == LAST_ROW) begin
          row_d  = '0;
          rptr_d = 2'd0;
        end else begin
          row_d  = row + 1'b1;
          rptr_d = rot3_next(rptr);
        end
      end else begin
        col_d  = col + 1'b1;
        cptr_d = rot3_next(cptr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      row  <= '0;
      cptr <= 2'd0;
      rptr <= 2'd0;
    end else if (adv) begin
      col  <= col_d;
      row  <= row_d;
      cptr <= cptr_d;
      rptr <= rptr_d;
    end
  end

  // R9: idle cycles leave the raster position untouched
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(col) && $stable(row) && $stable(cptr) && $stable(rptr)));

  // R10: frame wrap returns to the origin and buffer 0
  a_r10_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && col == LAST_COL && row == LAST_ROW) |=> (col == '0 && row == '0 && rptr == 2'd0));

  // R2: window slot pointer tracks column modulo 3
  a_r2_slot_tracks_col: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cptr) == (32'(col) % 32'd3)));

  // R6: buffer pointer tracks row modulo 3
  a_r6_bank_tracks_row: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rptr) == (32'(row) % 32'd3)));

endmodule

// File: rtl/hsr_window.sv
module hsr_window
  import hsr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             load,
  input  rot3_t            cptr,
  input  logic [PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0] tap_m1,
  output logic [PIX_W-1:0] tap_c,
  output logic [PIX_W-1:0] tap_p1
);

  logic [PIX_W-1:0] slot [3];

  always_ff @(posedge clk) begin
    for (int s = 0; s < 3; s++) begin
      if (load && cptr == rot3_t'(s)) slot[s] <= pix_in;
    end
  end

  // column c-2 sits in slot (c+1) mod 3, column c-1 in slot (c-1) mod 3
  always_comb begin
    tap_m1 = slot[rot3_next(cptr)];
    tap_c  = slot[rot3_prev(cptr)];
    tap_p1 = pix_in;
  end

endmodule

// File: rtl/hsr_kernel.sv
module hsr_kernel #(
  parameter int                  PIX_W   = 8,
  parameter int                  COEF_W  = 8,
  parameter int                  SHIFT   = 4,
  parameter logic [3*COEF_W-1:0] TAP_TBL = {8'd0, 8'd4, 8'd8}
) (
  input  logic [PIX_W-1:0] px_m1,
  input  logic [PIX_W-1:0] px_c,
  input  logic [PIX_W-1:0] px_p1,
  output logic [PIX_W-1:0] res
);

  localparam int ACC_W = PIX_W + COEF_W + 2;
  localparam int MAXV  = (1 << PIX_W) - 1;

  logic [2:0][PIX_W-1:0] px;
  logic [2:0][ACC_W-1:0] prod;
  logic [ACC_W-1:0]      acc;
  logic [ACC_W-1:0]      scaled;

  assign px = {px_p1, px_c, px_m1};

  for (genvar t = 0; t < 3; t++) begin : g_tap
    localparam int OFS  = t - 1;
    localparam int AIDX = (OFS < 0) ? -OFS : OFS;
    localparam logic [COEF_W-1:0] WGT = TAP_TBL[AIDX*COEF_W +: COEF_W];
    assign prod[t] = ACC_W'(px[t]) * ACC_W'(WGT);
  end

  always_comb begin
    acc    = prod[0] + prod[1] + prod[2];
    scaled = acc >> SHIFT;
    res    = (scaled > ACC_W'(MAXV)) ? PIX_W'(MAXV) : scaled[PIX_W-1:0];
  end

endmodule

// File: rtl/hsr_linebuf.sv
module hsr_linebuf #(
  parameter int COLS  = 8,
  parameter int PIX_W = 8,
  parameter int CW    = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_bank,
  input  logic [CW-1:0]    wr_col,
  input  logic [PIX_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_bank,
  input  logic [CW-1:0]    rd_col,
  output logic [PIX_W-1:0] rd_data
);

  logic [2:0][PIX_W-1:0] bank_rd;
  logic [PIX_W-1:0]      rd_sel;

  for (genvar b = 0; b < 3; b++) begin : g_bank
    logic [PIX_W-1:0] mem [COLS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 2'(b)) mem[wr_col] <= wr_data;
    end
    assign bank_rd[b] = mem[rd_col];
  end

  always_comb begin
    rd_sel = bank_rd[0];
    if (rd_bank == 2'd1) rd_sel = bank_rd[1];
    if (rd_bank == 2'd2) rd_sel = bank_rd[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  // R6: only three buffers exist
  a_r6_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != 2'd3));

  // R8: read data holds when no read is requested
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/hsmooth_rot3.sv
module hsmooth_rot3
  import hsr_pkg::*;
#(
  parameter int                  IMG_W   = 8,
  parameter int                  IMG_H   = 6,
  parameter int                  PIX_W   = 8,
  parameter int                  COEF_W  = 8,
  parameter int                  SHIFT   = 4,
  parameter logic [3*COEF_W-1:0] TAP_TBL = {8'd0, 8'd4, 8'd8}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pix_valid,
  input  logic [PIX_W-1:0]         pix_data,
  input  logic                     rd_en,
  input  logic [1:0]               rd_bank,
  input  logic [$clog2(IMG_W)-1:0] rd_col,
  output logic [PIX_W-1:0]         rd_data
);

  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);
  localparam logic [CW-1:0] LAST_COL = CW'(IMG_W - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(IMG_H - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [CW-1:0]    col;
  logic [RW-1:0]    row;
  rot3_t            cptr;
  rot3_t            rptr;
  logic [PIX_W-1:0] tap_m1, tap_c, tap_p1;
  logic [PIX_W-1:0] filt;

  hsr_raster #(.COLS(IMG_W), .ROWS(IMG_H), .CW(CW), .RW(RW)) u_raster (
    .clk  (clk),
    .rst_n(rst_n_i),
    .adv  (pix_valid),
    .col  (col),
    .row  (row),
    .cptr (cptr),
    .rptr (rptr)
  );

  hsr_window #(.PIX_W(PIX_W)) u_window (
    .clk   (clk),
    .load  (pix_valid),
    .cptr  (cptr),
    .pix_in(pix_data),
    .tap_m1(tap_m1),
    .tap_c (tap_c),
    .tap_p1(tap_p1)
  );

  hsr_kernel #(.PIX_W(PIX_W), .COEF_W(COEF_W), .SHIFT(SHIFT), .TAP_TBL(TAP_TBL)) u_kernel (
    .px_m1(tap_m1),
    .px_c (tap_c),
    .px_p1(tap_p1),
    .res  (filt)
  );

  // one write per accepted pixel: column 0 at c=0, the right border at c=1,
  // and the centre c-1 from c=2 on
  logic             wr_en_d, wr_en_q;
  logic [1:0]       wr_bank_d, wr_bank_q;
  logic [CW-1:0]    wr_col_d, wr_col_q;
  logic [PIX_W-1:0] wr_data_d, wr_data_q;
  logic             interior;

  always_comb begin
    interior  = (row != '0) && (row != LAST_ROW) && (col >= CW'(2));
    wr_en_d   = pix_valid;
    wr_bank_d = rptr;
    if (col == '0)           wr_col_d = '0;
    else if (col == CW'(1))  wr_col_d = LAST_COL;
    else                     wr_col_d = col - 1'b1;
    wr_data_d = interior ? filt : '0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) wr_en_q <= 1'b0;
    else          wr_en_q <= wr_en_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en_d) begin
      wr_bank_q <= wr_bank_d;
      wr_col_q  <= wr_col_d;
      wr_data_q <= wr_data_d;
    end
  end

  hsr_linebuf #(.COLS(IMG_W), .PIX_W(PIX_W), .CW(CW)) u_linebuf (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (wr_en_q),
    .wr_bank(wr_bank_q),
    .wr_col (wr_col_q),
    .wr_data(wr_data_q),
    .rd_en  (rd_en),
    .rd_bank(rd_bank),
    .rd_col (rd_col),
    .rd_data(rd_data)
  );

  // R8: a pixel beat produces exactly one write on the next cycle
  a_r8_write_follows_beat: assert property (@(posedge clk) disable iff (!rst_n_i)
    pix_valid |=> wr_en_q);
  a_r8_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n_i)
    !pix_valid |=> !wr_en_q);

  // R4: border columns are written as zero
  a_r4_border_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en_q && (wr_col_q == '0 || wr_col_q == LAST_COL)) |-> (wr_data_q == '0));

  // R5: first and last rows are written as zero
  a_r5_edge_rows_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pix_valid && (row == '0 || row == LAST_ROW)) |=> (wr_data_q == '0));

endmodule

// File: tb/hsmooth_rot3_tb_top.sv
module hsmooth_rot3_tb_top;

  localparam int W = 8;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_valid;
  logic [7:0] pix_data;
  logic       rd_en;
  logic [1:0] rd_bank;
  logic [2:0] rd_col;
  logic [7:0] rd_a, rd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] img [H][W];

  always #5 clk = ~clk;

  hsmooth_rot3 dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_a)
  );

  hsmooth_rot3 #(.TAP_TBL({8'd0, 8'd16, 8'd32})) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_b)
  );

  function automatic int rawv(int r, int c, int w0, int w1);
    return (w1 * (int'(img[r][c-1]) + int'(img[r][c+1])) + w0 * int'(img[r][c])) >> 4;
  endfunction

  function automatic int expv(int r, int c, int w0, int w1);
    int s;
    if (r == 0 || r == H-1 || c == 0 || c == W-1) return 0;
    s = rawv(r, c, w0, w1);
    return (s > 255) ? 255 : s;
  endfunction

  task automatic cmp(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic send_row(int r, bit gap);
    for (int c = 0; c < W; c++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = img[r][c];
      if (gap && (c % 3 == 1)) begin
        @(negedge clk);
        pix_valid = 1'b0;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  // read bank b, compare against image row r
  task automatic check_bank(int b, int r, string tag);
    for (int c = 0; c < W; c++) begin
      string ta, tb;
      @(negedge clk);
      rd_en   = 1'b1;
      rd_bank = 2'(b);
      rd_col  = 3'(c);
      @(negedge clk);
      rd_en = 1'b0;
      ta = (r == 0 || r == H-1) ? "R5" : (c == 0 || c == W-1) ? "R4" : tag;
      tb = ta;
      if (ta == tag && rawv(r, c, 32, 16) > 255) tb = "R7";
      cmp(ta, $sformatf("bank %0d row %0d col %0d (default)", b, r, c), int'(rd_a), expv(r, c, 8, 4));
      cmp(tb, $sformatf("bank %0d row %0d col %0d (saturating)", b, r, c), int'(rd_b), expv(r, c, 32, 16));
    end
  endtask

  task automatic run_frame(string tag, bit gap);
    for (int r = 0; r < H; r++) begin
      send_row(r, gap);
      check_bank(r % 3, r, tag);
    end
    check_bank(0, 3, "R6");
    check_bank(1, 4, "R6");
  endtask

  task automatic fill_ramp();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 8'(r * 30 + c * 7);
  endtask

  task automatic fill_mirror();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 8'(r * 30 + (W - 1 - c) * 7);
  endtask

  task automatic fill_hash(int seed);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 8'((r * 53 + c * 97 + seed * 29) % 256);
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0; pix_valid = 1'b0; pix_data = '0;
    rd_en = 1'b0; rd_bank = '0; rd_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "rd_data after reset (default)", int'(rd_a), 0);
    cmp("R1", "rd_data after reset (saturating)", int'(rd_b), 0);
  endtask

  task automatic test_ramp();
    fill_ramp();
    run_frame("R2", 1'b0);
  endtask

  // mirrored frame directly after the previous one: symmetry and frame wrap
  task automatic test_mirror_wrap();
    fill_mirror();
    run_frame("R3", 1'b0);
    check_bank(2, 5, "R10");
  endtask

  task automatic test_latency();
    int a = expv(4, 2, 8, 4);
    int b = expv(4, 3, 8, 4);
    @(negedge clk);
    rd_en = 1'b1; rd_bank = 2'd1; rd_col = 3'd2;
    @(negedge clk);
    cmp("R8", "read col 2 after one edge", int'(rd_a), a);
    rd_col = 3'd3;
    #3;
    cmp("R8", "old data held before next edge", int'(rd_a), a);
    @(negedge clk);
    cmp("R8", "read col 3 after one edge", int'(rd_a), b);
    rd_en = 1'b0;
  endtask

  task automatic test_gaps();
    fill_hash(1);
    run_frame("R9", 1'b1);
  endtask

  task automatic test_midrow_reset();
    fill_hash(5);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = 8'(c * 41 + 9);
    end
    @(negedge clk);
    pix_valid = 1'b0;
    rst_n     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1", "rd_data after mid-row reset", int'(rd_a), 0);
    run_frame("R1", 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    test_ramp();
    test_mirror_wrap();
    test_latency();
    test_gaps();
    test_midrow_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule